// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins an A bus and a B bus through two independent data paths, one carrying A towards B and one carrying B towards A. Each path holds one storage word that can be transparent, can hold its contents, or can load on a rising edge of its own device clock. A clock-enable gates that load. Each path has an active-low output enable that puts its outputs into the high-impedance state.

The buses are modelled without real tri-state nets. Each bus input comes with a per-bit "driven" mask, and each output comes with an enable flag. A bus-hold keeper on each side supplies the last resolved level for any bit that nobody drives. Device clocks are ordinary data inputs. They are sampled in the system clock domain, and their rising edges are detected there. The transparent path is a combinational bypass around the storage register.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's latch enable is 1, its output data equals that path's resolved input word in the same cycle.
- R2: While latch enable is 0 and the device clock shows no rising edge, the output data keeps its value even when the input data changes.
- R3: With latch enable 0 and clock enable 0, a 0-to-1 change of the device clock seen at a system clock edge loads the resolved input word present at that edge. The output shows the new word after that edge.
- R4: With clock enable at 1, device clock edges have no effect and the output keeps the stored word.
- R5: While latch enable is 1, toggling the device clock and clock enable has no effect, and the output keeps following the input.
- R6: Output enable is active low. A 1 drives that path's out-enable flag to 0, and a 0 drives it to 1.
- R7: The B-to-A path behaves like the A-to-B path. It uses its own latch enable, device clock, clock enable and output enable, and writes onto the A side.
- R8: A bus bit whose driven-mask bit is 0 takes the level the keeper holds for it, which is the last resolved level. A bit whose mask bit is 1 takes the external input.
- R9: While this block drives a bus, that side's keeper takes the driven word, and it returns that word once every driver goes away.
- R10: Reset is synchronous and active low. It clears both storage words and both keepers to zero.
- R11: The contention flag is 1 exactly when both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | External level on the A bus |
| a_drv | input | W | Per-bit mask, 1 where an outside source drives A |
| b_in | input | W | External level on the B bus |
| b_drv | input | W | Per-bit mask, 1 where an outside source drives B |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_dclk | input | 1 | A-to-B device clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_dclk | input | 1 | B-to-A device clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | W | Word offered to the B bus |
| b_out_en | output | 1 | 1 when b_out drives the B bus |
| a_out | output | W | Word offered to the A bus |
| a_out_en | output | 1 | 1 when a_out drives the A bus |
| contention | output | 1 | Both directions driving at once |

## Verification
A storage word that is wrong stays hidden while its path is transparent. It shows up on the output data in the first cycle after latch enable drops, so the bench checks the held and clocked modes right after leaving transparency. A keeper that is wrong shows nothing until the mask releases a bit. After that, the wrong level reaches the far side in the same cycle through a transparent path. A missed or extra device-clock edge shows as a wrong word one system cycle after the edge.

// File: rtl/xcvr_pkg.sv
// Shared constants for the bidirectional transceiver.
// Assumes: direction index 0 carries A to B and index 1 carries B to A.
package xcvr_pkg;
    localparam int DEF_W = 18;
    localparam int NUM_DIR = 2;
    typedef enum logic {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } dir_e;
endpackage

// File: rtl/xcvr_keeper.sv
// Bus-hold keeper for one bus side.
// What it does: resolves each bit from the external driver, or from the held
// level when nothing outside drives it, and tracks the last resolved level.
// Assumes: own_en marks this block driving the same bus with own_val.
module xcvr_keeper #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pin_drv,
    input  logic [W-1:0] own_val,
    input  logic         own_en,
    output logic [W-1:0] level
);
    logic [W-1:0] hold_q;

    // Pick the external level per bit and fall back to the held level.
    always_comb begin
        level = (pin_in & pin_drv) | (hold_q & ~pin_drv);
    end

    // Remember the bus level: our own drive wins, otherwise the resolved level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (own_en) begin
            hold_q <= own_val;
        end else begin
            hold_q <= level;
        end
    end
endmodule

// File: rtl/xcvr_store.sv
// One direction's storage word with transparent, hold and clocked modes.
// What it does: a latch enable of 1 bypasses the register combinationally and
// keeps it loaded. Otherwise a sampled rising device-clock edge loads it when
// the active-low clock enable is 0.
// Assumes: dclk is synchronous to clk and wider than one clk period per phase.
module xcvr_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         le,
    input  logic         dclk,
    input  logic         ce_n,
    input  logic         oe_n,
    output logic [W-1:0] q,
    output logic         q_en
);
    logic [W-1:0] word_q;
    logic         dclk_q;
    logic         rise;

    // Delay the device clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        dclk_q <= dclk;
    end

    // Flag a 0-to-1 change of the device clock.
    always_comb begin
        rise = dclk & ~dclk_q;
    end

    // Load in transparent mode or on an enabled device-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (le || (rise && !ce_n)) begin
            word_q <= d;
        end
    end

    // Bypass the register while transparent; gate the drive flag.
    always_comb begin
        q    = le ? d : word_q;
        q_en = ~oe_n;
    end
endmodule

// File: rtl/bus_xcvr.sv
// Top of the bidirectional latch/register transceiver.
// What it does: connects a keeper on each bus side and a storage path for
// each direction, and flags when both directions drive at once.
// Assumes: tri-state buses are modelled as level plus driven-mask inputs and
// data plus enable outputs.
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    input  logic         ab_le,
    input  logic         ab_dclk,
    input  logic         ab_ce_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_dclk,
    input  logic         ba_ce_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_out_en,
    output logic [W-1:0] a_out,
    output logic         a_out_en,
    output logic         contention
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;

    logic [W-1:0] side_in  [NUM_DIR];
    logic [W-1:0] side_drv [NUM_DIR];
    logic [W-1:0] side_eff [NUM_DIR];
    logic [W-1:0] dir_q    [NUM_DIR];
    logic         dir_en   [NUM_DIR];
    logic         dir_le   [NUM_DIR];
    logic         dir_clk  [NUM_DIR];
    logic         dir_ce_n [NUM_DIR];
    logic         dir_oe_n [NUM_DIR];

    // Gather the per-direction controls and bus sides into arrays.
    always_comb begin
        side_in[DIR_AB]  = a_in;
        side_drv[DIR_AB] = a_drv;
        side_in[DIR_BA]  = b_in;
        side_drv[DIR_BA] = b_drv;
        dir_le[DIR_AB]   = ab_le;
        dir_clk[DIR_AB]  = ab_dclk;
        dir_ce_n[DIR_AB] = ab_ce_n;
        dir_oe_n[DIR_AB] = ab_oe_n;
        dir_le[DIR_BA]   = ba_le;
        dir_clk[DIR_BA]  = ba_dclk;
        dir_ce_n[DIR_BA] = ba_ce_n;
        dir_oe_n[DIR_BA] = ba_oe_n;
    end

    // One keeper per bus side and one storage path per direction.
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        localparam int OPP = NUM_DIR - 1 - g;

        // Keeper on the source side of direction g; direction OPP drives it.
        xcvr_keeper #(.W(W)) keep_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (side_in[g]),
            .pin_drv (side_drv[g]),
            .own_val (dir_q[OPP]),
            .own_en  (dir_en[OPP]),
            .level   (side_eff[g])
        );

        xcvr_store #(.W(W)) store_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (side_eff[g]),
            .le    (dir_le[g]),
            .dclk  (dir_clk[g]),
            .ce_n  (dir_ce_n[g]),
            .oe_n  (dir_oe_n[g]),
            .q     (dir_q[g]),
            .q_en  (dir_en[g])
        );
    end

    // Map the direction results back onto named ports.
    always_comb begin
        a_eff      = side_eff[DIR_AB];
        b_eff      = side_eff[DIR_BA];
        b_out      = dir_q[DIR_AB];
        b_out_en   = dir_en[DIR_AB];
        a_out      = dir_q[DIR_BA];
        a_out_en   = dir_en[DIR_BA];
        contention = !ab_oe_n && !ba_oe_n;
    end
endmodule

// Checker for the transceiver, attached through bind below.
// What it does: checks path modes, enables, keeper and reset over time.
// Assumes: it sees the top-level ports plus the resolved side levels.
module xcvr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_drv,
    input logic         ab_le,
    input logic         ab_dclk,
    input logic         ab_ce_n,
    input logic         ab_oe_n,
    input logic         ba_le,
    input logic         ba_oe_n,
    input logic [W-1:0] a_eff,
    input logic [W-1:0] b_eff,
    input logic [W-1:0] b_out,
    input logic         b_out_en,
    input logic [W-1:0] a_out,
    input logic         a_out_en,
    input logic         contention
);
    AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_eff)); // R1
    AST_AB_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !(ab_dclk && !$past(ab_dclk))) |=> (ab_le || $stable(b_out))); // R2
    AST_AB_CLOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_ce_n && ab_dclk && !$past(ab_dclk)) |=> (ab_le || b_out == $past(a_eff))); // R3
    AST_AB_CE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_ce_n) |=> (ab_le || $stable(b_out))); // R4
    AST_AB_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> !b_out_en); // R6
    AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_eff)); // R7
    AST_BA_OE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe_n |-> a_out_en); // R7
    AST_A_KEEPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv == '0 && $past(a_drv) == '1 && !$past(a_out_en)) |-> (a_eff == $past(a_in))); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || ab_le || b_out == '0)); // R10
    AST_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        contention == (!ab_oe_n && !ba_oe_n)); // R11
endmodule

bind bus_xcvr xcvr_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_in       (a_in),
    .a_drv      (a_drv),
    .ab_le      (ab_le),
    .ab_dclk    (ab_dclk),
    .ab_ce_n    (ab_ce_n),
    .ab_oe_n    (ab_oe_n),
    .ba_le      (ba_le),
    .ba_oe_n    (ba_oe_n),
    .a_eff      (a_eff),
    .b_eff      (b_eff),
    .b_out      (b_out),
    .b_out_en   (b_out_en),
    .a_out      (a_out),
    .a_out_en   (a_out_en),
    .contention (contention)
);

// File: tb/bus_xcvr_tb_top.sv
// Directed bench: one task per scenario; inputs change on the falling edge,
// checks sample 1 ns later.
module bus_xcvr_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, a_drv, b_in, b_drv;
    logic         ab_le, ab_dclk, ab_ce_n, ab_oe_n;
    logic         ba_le, ba_dclk, ba_ce_n, ba_oe_n;
    logic [W-1:0] b_out, a_out;
    logic         b_out_en, a_out_en, contention;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
        .ab_le(ab_le), .ab_dclk(ab_dclk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_dclk(ba_dclk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en),
        .contention(contention)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = '1; a_drv = '0; b_in = '1; b_drv = '0;
        ab_le = 1'b0; ab_dclk = 1'b0; ab_ce_n = 1'b1; ab_oe_n = 1'b1;
        ba_le = 1'b0; ba_dclk = 1'b0; ba_ce_n = 1'b1; ba_oe_n = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        settle();
        chk("R10 b store zero", b_out, '0);
        chk("R10 a store zero", a_out, '0);
        chk("R11 idle flag", {{(W-1){1'b0}}, contention}, '0);
        step();
        ab_le = 1'b1; ba_le = 1'b1;
        settle();
        chk("R10 A keeper zero", b_out, '0);
        chk("R10 B keeper zero", a_out, '0);
        step();
        ab_le = 1'b0; ba_le = 1'b0;
    endtask

    task automatic t_transparent();
        step();
        a_drv = '1; a_in = 18'h2A5C3; ab_le = 1'b1; ab_oe_n = 1'b0;
        settle();
        chk("R1 follow first", b_out, 18'h2A5C3);
        step();
        a_in = 18'h15A3C;
        settle();
        chk("R1 follow second", b_out, 18'h15A3C);
        step();
        ab_ce_n = 1'b0; ab_dclk = 1'b1; a_in = 18'h0F0F0;
        step();
        ab_dclk = 1'b0; ab_ce_n = 1'b1; a_in = 18'h30303;
        settle();
        chk("R5 clock ignored while transparent", b_out, 18'h30303);
    endtask

    task automatic t_hold();
        step();
        a_in = 18'h12345;
        step();
        ab_le = 1'b0;
        settle();
        chk("R2 latched on le fall", b_out, 18'h12345);
        step();
        a_in = 18'h3FFFF;
        step();
        settle();
        chk("R2 hold under input change", b_out, 18'h12345);
    endtask

    task automatic t_clocked();
        step();
        ab_ce_n = 1'b0; a_in = 18'h0ABCD;
        ab_dclk = 1'b1;
        step();
        settle();
        chk("R3 load on rising edge", b_out, 18'h0ABCD);
        a_in = 18'h11111;
        step();
        settle();
        chk("R3 no reload while high", b_out, 18'h0ABCD);
        ab_dclk = 1'b0;
        step();
        settle();
        chk("R3 falling edge ignored", b_out, 18'h0ABCD);
    endtask

    task automatic t_ce();
        step();
        ab_ce_n = 1'b1; a_in = 18'h22222; ab_dclk = 1'b1;
        step();
        settle();
        chk("R4 disabled edge ignored", b_out, 18'h0ABCD);
        ab_dclk = 1'b0;
    endtask

    task automatic t_oe();
        step();
        ab_oe_n = 1'b1;
        settle();
        chk("R6 oe high disables", {{(W-1){1'b0}}, b_out_en}, '0);
        step();
        ab_oe_n = 1'b0;
        settle();
        chk("R6 oe low enables", {{(W-1){1'b0}}, b_out_en}, 18'h1);
        ab_oe_n = 1'b1;
    endtask

    task automatic t_ba();
        step();
        b_drv = '1; b_in = 18'h0C3C3; ba_le = 1'b1; ba_oe_n = 1'b0;
        settle();
        chk("R7 transparent B to A", a_out, 18'h0C3C3);
        chk("R7 enable", {{(W-1){1'b0}}, a_out_en}, 18'h1);
        step();
        ba_le = 1'b0; ba_ce_n = 1'b0; b_in = 18'h35353; ba_dclk = 1'b1;
        step();
        settle();
        chk("R7 clocked B to A", a_out, 18'h35353);
        ba_dclk = 1'b0; ba_ce_n = 1'b1; ba_oe_n = 1'b1;
    endtask

    task automatic t_keeper();
        logic [W-1:0] msk;
        step();
        a_drv = '1; a_in = 18'h2D2D2; ab_le = 1'b1;
        step();
        a_drv = '0; a_in = 18'h15555;
        settle();
        chk("R8 released bits keep level", b_out, 18'h2D2D2);
        msk = 18'h000FF;
        step();
        a_drv = msk; a_in = 18'h3FF00;
        settle();
        chk("R8 mixed mask", b_out, (18'h3FF00 & msk) | (18'h2D2D2 & ~msk));
    endtask

    task automatic t_own();
        step();
        b_drv = '1; b_in = 18'h26B4A; ba_le = 1'b1; ba_oe_n = 1'b0;
        a_drv = '0; ab_le = 1'b0;
        step();
        ba_oe_n = 1'b1;
        step();
        ab_le = 1'b1;
        settle();
        chk("R9 keeper took own drive", b_out, 18'h26B4A);
        ba_le = 1'b0;
    endtask

    task automatic t_contention();
        step();
        ab_oe_n = 1'b0; ba_oe_n = 1'b0;
        settle();
        chk("R11 both enabled", {{(W-1){1'b0}}, contention}, 18'h1);
        step();
        ba_oe_n = 1'b1;
        settle();
        chk("R11 one enabled", {{(W-1){1'b0}}, contention}, '0);
        ab_oe_n = 1'b1;
    endtask

    initial begin : watchdog
        #(100000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_transparent();
        t_hold();
        t_clocked();
        t_ce();
        t_oe();
        t_ba();
        t_keeper();
        t_own();
        t_contention();
        step();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule